// File: doc/BRIEF.md
# Reuse filter cache front-end

This block is a small, fully associative filter that sits beside a main cache. It keeps new lines out of the main cache until they show reuse. Each lookup arrives with a line tag, and the main cache reports in the same cycle whether it holds that line. When both structures miss, the block reports a miss and waits for memory to return the line. The returned line is written only into the filter.

When a line that is resident in the filter is looked up a second time, the lookup is answered as a hit. The block then sends the line's tag to the main cache as a one-cycle promotion pulse and drops the line from the filter, so the two structures never hold the same line. Lines that are never looked up again leave the filter through least-recently-filled replacement and never reach the main cache. A hit in the main cache leaves the filter untouched.

The controller has two named states. In READY it accepts lookups, and in WAIT_FILL it waits for memory. A lookup that misses in both structures moves READY to WAIT_FILL. In WAIT_FILL, a memory fill moves the block back to READY. Every other event keeps the current state.

Top module: `reuse_filter_fe`

## Requirements
- R1: During and straight after reset, req_ready is 1, resp_valid and promo_valid are 0, and the filter is empty, so the first lookup of any tag with main_hit low misses.
- R2: A lookup accepted while main_hit is 0 and the tag is not in the filter produces resp_valid=1, resp_hit=0 and resp_filt=0 in the next cycle. From that cycle, req_ready stays 0 until a fill is taken.
- R3: In WAIT_FILL, fill_valid=1 writes fill_tag into the filter. req_ready is 1 again in the cycle after the fill, and the fill raises no promotion.
- R4: A lookup accepted while main_hit is 0 and the tag is resident in the filter produces, in the next cycle, resp_valid=1, resp_hit=1 and resp_filt=1, together with promo_valid=1 and promo_tag equal to the tag.
- R5: A promoted line is removed from the filter, so a later lookup of the same tag with main_hit low misses.
- R6: A lookup accepted while main_hit is 1 answers resp_hit=1 and resp_filt=0 with no promotion, and the filter is unchanged. A tag resident in the filter stays resident.
- R7: A fill goes to a free entry when one exists. When all 8 entries are valid, the fill replaces the line that was filled earliest, and that line then misses.
- R8: fill_valid asserted while in READY is ignored and writes nothing into the filter.
- R9: req_valid asserted while req_ready is 0 is ignored and produces no response.
- R10: promo_valid is high for exactly one cycle per filter hit and is 0 in any cycle whose previous cycle accepted no filter-hit lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_tag | input | TAG_W | Line tag of the lookup |
| req_ready | output | 1 | High in READY; lookups are accepted only then |
| main_hit | input | 1 | Main cache holds the looked-up line (same cycle as req_valid) |
| fill_valid | input | 1 | Memory returns a line |
| fill_tag | input | TAG_W | Tag of the returned line |
| resp_valid | output | 1 | Response to the lookup accepted in the previous cycle |
| resp_hit | output | 1 | Lookup hit in the main cache or the filter |
| resp_filt | output | 1 | Lookup hit in the filter |
| promo_valid | output | 1 | One-cycle promotion pulse towards the main cache |
| promo_tag | output | TAG_W | Tag of the promoted line |

## Verification
A stuck or wrong valid bit shows up at the next lookup of that tag. The lookup either misses where a promotion was due, or it promotes a line that was already promoted or evicted. Either way the error is visible one cycle after the lookup is accepted. A wrong age ordering in the replacement logic is only seen once the filter is full and a later fill evicts the wrong line. It therefore appears as a wrong hit or miss on a later lookup, several accesses after the fault. The randomized sweep below keeps more live tags than there are entries, so such faults are exposed. A controller stuck in WAIT_FILL shows as req_ready staying low one cycle after a fill.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [0:0] {
        ST_READY     = 1'b0,
        ST_WAIT_FILL = 1'b1
    } fc_state_e;
endpackage

// File: rtl/fc_tag_store.sv
module fc_tag_store #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 12,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic [ENTRIES-1:0] hit_vec,
    input  logic               inv_en,
    input  logic [IDX_W-1:0]   inv_idx,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    output logic [ENTRIES-1:0] valid_vec
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (inv_en) valid_q[inv_idx] <= 1'b0;
            if (wr_en)  valid_q[wr_idx]  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_tag);
        end
    endgenerate

    assign valid_vec = valid_q;

    // R4
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R5
    no_wr_inv_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_en && wr_en));
endmodule

// File: rtl/fc_lru_matrix.sv
module fc_lru_matrix #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] victim_vec
);
    // older_q[i][j] = 1 when entry i was filled before entry j
    logic [ENTRIES-1:0] older_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) older_q[i] <= '0;
        end else if (touch_en) begin
            for (int j = 0; j < ENTRIES; j++) begin
                older_q[touch_idx][j] <= 1'b0;
                older_q[j][touch_idx] <= (IDX_W'(j) != touch_idx);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            victim_vec[i] = valid_vec[i];
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && valid_vec[j] && !older_q[i][j]) victim_vec[i] = 1'b0;
            end
        end
    end

    // R7
    lru_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_vec) |-> ($countones(victim_vec) == 1));
endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
    import fc_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             main_hit,
    input  logic             filt_hit,
    input  logic             fill_valid,
    output logic             req_ready,
    output logic             do_promote,
    output logic             do_fill,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic             resp_filt,
    output logic             promo_valid,
    output logic [TAG_W-1:0] promo_tag
);
    fc_state_e state_q, state_d;
    logic acc, miss_now;

    assign req_ready  = (state_q == ST_READY);
    assign acc        = req_valid && req_ready;
    assign do_promote = acc && !main_hit && filt_hit;
    assign miss_now   = acc && !main_hit && !filt_hit;
    assign do_fill    = (state_q == ST_WAIT_FILL) && fill_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:     if (miss_now)   state_d = ST_WAIT_FILL;
            ST_WAIT_FILL: if (fill_valid) state_d = ST_READY;
            default:                      state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_filt   <= 1'b0;
            promo_valid <= 1'b0;
            promo_tag   <= '0;
        end else begin
            resp_valid  <= acc;
            resp_hit    <= acc && (main_hit || filt_hit);
            resp_filt   <= do_promote;
            promo_valid <= do_promote;
            if (do_promote) promo_tag <= req_tag;
        end
    end

    // R2
    miss_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (state_q == ST_WAIT_FILL && !req_ready));

    // R3
    fill_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_fill |=> (req_ready && !promo_valid));

    // R10
    promo_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        promo_valid |-> (resp_valid && resp_hit && resp_filt));

    // R9
    stall_noresp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_FILL) |=> !resp_valid);
endmodule

// File: rtl/reuse_filter_fe.sv
module reuse_filter_fe #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    output logic             req_ready,
    input  logic             main_hit,
    input  logic             fill_valid,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic             resp_filt,
    output logic             promo_valid,
    output logic [TAG_W-1:0] promo_tag
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] hit_vec, valid_vec, victim_vec;
    logic [IDX_W-1:0]   hit_idx, free_idx, vict_idx, slot_idx;
    logic               filt_hit, do_promote, do_fill;

    assign filt_hit = |hit_vec;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        vict_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i])     hit_idx  = IDX_W'(i);
            if (!valid_vec[i])  free_idx = IDX_W'(i);
            if (victim_vec[i])  vict_idx = IDX_W'(i);
        end
        slot_idx = (&valid_vec) ? vict_idx : free_idx;
    end

    fc_ctrl #(.TAG_W(TAG_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_tag     (req_tag),
        .main_hit    (main_hit),
        .filt_hit    (filt_hit),
        .fill_valid  (fill_valid),
        .req_ready   (req_ready),
        .do_promote  (do_promote),
        .do_fill     (do_fill),
        .resp_valid  (resp_valid),
        .resp_hit    (resp_hit),
        .resp_filt   (resp_filt),
        .promo_valid (promo_valid),
        .promo_tag   (promo_tag)
    );

    fc_tag_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_tag    (req_tag),
        .hit_vec   (hit_vec),
        .inv_en    (do_promote),
        .inv_idx   (hit_idx),
        .wr_en     (do_fill),
        .wr_idx    (slot_idx),
        .wr_tag    (fill_tag),
        .valid_vec (valid_vec)
    );

    fc_lru_matrix #(.ENTRIES(ENTRIES)) lru_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (do_fill),
        .touch_idx  (slot_idx),
        .valid_vec  (valid_vec),
        .victim_vec (victim_vec)
    );

    // R5
    promo_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_promote |=> !valid_vec[$past(hit_idx)]);

    // R6
    main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && main_hit) |=> $stable(valid_vec));

    // R8
    ready_fill_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && fill_valid && !(req_valid && !main_hit && filt_hit)) |=> $stable(valid_vec));

    // R7
    full_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_fill && (&valid_vec)) |=> (&valid_vec));
endmodule

// File: tb/reuse_filter_fe_tb_top.sv
`timescale 1ns/1ps
module reuse_filter_fe_tb_top;
    localparam int ENTRIES = 8;
    localparam int TAG_W   = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid, main_hit, fill_valid;
    logic [TAG_W-1:0] req_tag, fill_tag;
    logic             req_ready, resp_valid, resp_hit, resp_filt, promo_valid;
    logic [TAG_W-1:0] promo_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model of the filter contents
    bit               mv [ENTRIES];
    logic [TAG_W-1:0] mt [ENTRIES];
    int               ms [ENTRIES];
    int               seq = 0;
    bit               main_has [16];

    always #2.5 clk = ~clk;

    reuse_filter_fe #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .req_ready(req_ready), .main_hit(main_hit), .fill_valid(fill_valid),
        .fill_tag(fill_tag), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_filt(resp_filt), .promo_valid(promo_valid), .promo_tag(promo_tag)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int m_find(input logic [TAG_W-1:0] t);
        for (int i = 0; i < ENTRIES; i++) if (mv[i] && mt[i] == t) return i;
        return -1;
    endfunction

    task automatic m_insert(input logic [TAG_W-1:0] t);
        int slot = -1;
        for (int i = 0; i < ENTRIES; i++) if (!mv[i] && slot < 0) slot = i;
        if (slot < 0) begin
            slot = 0;
            for (int i = 1; i < ENTRIES; i++) if (ms[i] < ms[slot]) slot = i;
        end
        mv[slot] = 1'b1; mt[slot] = t; ms[slot] = seq; seq++;
    endtask

    // one lookup, with fill on a double miss; returns 1 when a promotion occurred
    task automatic access(input logic [TAG_W-1:0] t, input bit mh, input bit stall,
                          output bit promoted);
        int    f = m_find(t);
        bit    e_filt = !mh && (f >= 0);
        bit    e_hit  = mh || (f >= 0);
        string rq = mh ? "R6" : (e_filt ? "R4" : "R2");
        req_valid = 1'b1; req_tag = t; main_hit = mh;
        @(negedge clk);
        req_valid = 1'b0; main_hit = 1'b0;
        chk({resp_valid, resp_hit, resp_filt, promo_valid} == {1'b1, e_hit, e_filt, e_filt},
            rq, "resp/promo flags", {resp_valid, resp_hit, resp_filt, promo_valid},
            {1'b1, e_hit, e_filt, e_filt});
        if (e_filt) begin
            chk(promo_tag == t, "R4", "promo_tag", promo_tag, t);
            mv[f] = 1'b0;
        end
        promoted = e_filt;
        if (!e_hit) begin
            chk(req_ready == 1'b0, "R2", "req_ready in wait", req_ready, 0);
            if (stall) begin
                req_valid = 1'b1; req_tag = t + 1;
                @(negedge clk);
                req_valid = 1'b0;
                chk({resp_valid, req_ready} == 2'b00, "R9", "stalled request",
                    {resp_valid, req_ready}, 0);
            end
            fill_valid = 1'b1; fill_tag = t;
            @(negedge clk);
            fill_valid = 1'b0;
            chk({req_ready, promo_valid, resp_valid} == 3'b100, "R3", "after fill",
                {req_ready, promo_valid, resp_valid}, 3'b100);
            m_insert(t);
        end else begin
            @(negedge clk);
            chk({promo_valid, resp_valid} == 2'b00, "R10", "promo pulse end",
                {promo_valid, resp_valid}, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit        p;
        logic [15:0] lf = 16'hACE1;
        for (int i = 0; i < ENTRIES; i++) begin mv[i] = 0; mt[i] = '0; ms[i] = 0; end
        for (int i = 0; i < 16; i++) main_has[i] = 0;
        rst_n = 1'b0; req_valid = 0; main_hit = 0; fill_valid = 0;
        req_tag = '0; fill_tag = '0;
        repeat (3) @(negedge clk);
        chk({req_ready, resp_valid, promo_valid} == 3'b100, "R1", "reset outputs",
            {req_ready, resp_valid, promo_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk({req_ready, resp_valid, promo_valid} == 3'b100, "R1", "after reset",
            {req_ready, resp_valid, promo_valid}, 3'b100);

        access(12'h005, 0, 0, p);             // R1: empty filter misses
        chk(p == 0, "R1", "first lookup promoted", p, 0);
        access(12'h005, 0, 0, p);             // R4: second access promotes
        chk(p == 1, "R4", "second lookup promotion", p, 1);
        access(12'h005, 0, 0, p);             // R5: promoted line gone
        chk(p == 0, "R5", "lookup after promotion", p, 0);
        access(12'h005, 1, 0, p);             // R6: main hit leaves filter
        access(12'h005, 0, 0, p);
        chk(p == 1, "R6", "line kept across main hit", p, 1);

        // R8: fill in READY ignored
        fill_valid = 1'b1; fill_tag = 12'h009;
        @(negedge clk);
        fill_valid = 1'b0;
        chk(resp_valid == 0, "R8", "no response to stray fill", resp_valid, 0);
        access(12'h009, 0, 0, p);
        chk(p == 0, "R8", "stray fill installed line", p, 0);

        access(12'h033, 0, 1, p);             // R9: request during wait ignored

        // R7: fill beyond capacity evicts the earliest filled line
        for (int i = 0; i < ENTRIES + 1; i++) access(12'h100 + 12'(i), 0, 0, p);
        access(12'h100, 0, 0, p);
        chk(p == 0, "R7", "earliest line evicted", p, 0);
        access(12'h108, 0, 0, p);
        chk(p == 1, "R7", "newest line resident", p, 1);

        // sweep over a pool of 16 tags with a main-cache stub
        for (int n = 0; n < 3000; n++) begin
            int idx;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            idx = int'(lf[3:0]);
            if (n % 64 == 0) for (int k = 0; k < 16; k++) main_has[k] = 0;
            access(12'h200 + 12'(idx), main_has[idx], (n % 97) == 0, p);
            if (p) main_has[idx] = 1;
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule